// File: doc/BRIEF.md
# Variable-Length Record Ring Cache

This block keeps recently fetched records of varying length in a single circular byte buffer, so that a repeated fetch of the same record is served on chip instead of from slow external memory. Each record is named by an ID. A lookup either hits, and the stored bytes stream out one per cycle, or misses. On a miss the block asks a memory port for the record. The port answers with a length header and then the data bytes, which the block forwards to the requester as they arrive.

A missed record whose length is within a programmable limit (0 to 255 bytes) and within the buffer size is also written at the buffer head while it is forwarded. A longer record is only forwarded. Before a store, space is reclaimed from the buffer tail one whole record at a time, always the one that was inserted earliest. This continues until the free bytes cover the new record and the directory has a free entry. Records are packed end to end and may wrap past the last byte address, so the free space is always one contiguous region. A small fully associative directory holds ID, offset and length for every live record.

Top module: `rec_ring_cache`

## Requirements
- R1: After reset `req_ready` is 1, `out_valid`, `mem_req_valid` and `mem_dat_ready` are 0, and the cache holds no record, so the first lookup of any ID misses.
- R2: On a miss the block raises `mem_req_valid` with `mem_req_id` equal to the looked-up ID and holds both stable until `mem_req_ready`. It then takes one `mem_hdr_len` beat (length 1..255). Each data byte accepted while `mem_dat_ready` and `mem_dat_valid` are both 1 appears on `out_byte` in the same cycle with `out_valid` = 1, and `out_last` = 1 on the byte numbered by the header length.
- R3: A lookup of a stored ID issues no memory request. Its bytes appear in their original order, one per cycle, in the cycles that follow acceptance without gaps, and `out_last` marks the final byte.
- R4: A missed record is stored only if its length is at most `cfg_max_len`. A record one byte over the limit misses again on the next lookup, a record exactly at the limit hits, and a limit of 0 stores nothing.
- R5: A record longer than the buffer (`RING_BYTES`) is forwarded but never stored.
- R6: Before a store, whole records are reclaimed from the tail in insertion order until the free bytes are at least the new length. Reclaimed IDs miss afterwards, and records inserted later still hit. Stored bytes never overwrite live ones.
- R7: If every directory entry is live, the oldest record is reclaimed even when enough byte space is free. The remaining records keep hitting.
- R8: A record stored across the end of the buffer reads back byte-exact.
- R9: Reclaim order follows insertion by miss only: a hit on the oldest record does not protect it from being reclaimed next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_len | input | 8 | Largest record length that may be stored |
| req_valid | input | 1 | Lookup request |
| req_id | input | ID_W | ID to look up |
| req_ready | output | 1 | Block idle, lookup accepted this cycle |
| out_valid | output | 1 | Record byte valid |
| out_byte | output | 8 | Record byte |
| out_last | output | 1 | Final byte of the record |
| mem_req_valid | output | 1 | Memory fetch request |
| mem_req_id | output | ID_W | ID to fetch |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_hdr_valid | input | 1 | Length header valid |
| mem_hdr_len | input | 8 | Record length from memory |
| mem_dat_valid | input | 1 | Memory data byte valid |
| mem_dat_byte | input | 8 | Memory data byte |
| mem_dat_ready | output | 1 | Block accepts data bytes |

## Verification
The main function is tried with four patterns. The first is a cold miss followed by a repeat hit, which separates the forwarding path from the buffer read path. The second is a series of records at, one over and far over the limit, which separates storage from pure forwarding. The third is a sequence that fills the byte space, so that only the correct insertion-order reclaim keeps exactly the expected IDs live. Because the oldest record was hit just before, this pattern also separates reclaim by miss order from recency of use. The fourth is a burst of small records that exhausts the directory before the bytes, which separates the entry-count reclaim from the byte-count reclaim. One record is placed across the buffer end to expose any error in wrap-around addressing. Memory data arrives with gaps, so forwarding is checked against real handshakes rather than a fixed cadence.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIT,
    ST_MREQ,
    ST_HDR,
    ST_EVICT,
    ST_FILL
  } rrc_state_e;

  // Ring pointer advance, modulo the buffer size (step never exceeds size).
  function automatic logic [15:0] rrc_wrap_add(input logic [15:0] base,
                                               input logic [15:0] step,
                                               input logic [15:0] size);
    logic [16:0] sum;
    sum = {1'b0, base} + {1'b0, step};
    if (sum >= {1'b0, size}) sum = sum - {1'b0, size};
    return sum[15:0];
  endfunction

  // A record is stored only if it is non-empty, within the limit and within the ring.
  function automatic logic rrc_storable(input logic [7:0]  len,
                                        input logic [7:0]  limit,
                                        input logic [15:0] ring);
    return (len != 8'd0) && (len <= limit) && ({8'd0, len} <= ring);
  endfunction

  // Free bytes left in the ring.
  function automatic logic [15:0] rrc_free(input logic [15:0] used,
                                           input logic [15:0] ring);
    return ring - used;
  endfunction

endpackage

// File: rtl/rrc_ring.sv
module rrc_ring #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/rrc_dir.sv
module rrc_dir #(
  parameter int ENTRIES = 4,
  parameter int ID_W    = 8,
  parameter int AW      = 6,
  parameter int IXW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  // lookup
  input  logic [ID_W-1:0] lk_id,
  output logic            lk_hit,
  output logic [AW-1:0]   lk_off,
  output logic [7:0]      lk_len,
  // oldest record, found by its start offset
  input  logic [AW-1:0]   tail_off,
  output logic            tail_hit,
  output logic [7:0]      tail_len,
  input  logic            inv_en,
  // allocation
  output logic            full,
  output logic [IXW-1:0]  free_idx,
  input  logic            wr_en,
  input  logic [IXW-1:0]  wr_idx,
  input  logic [ID_W-1:0] wr_id,
  input  logic [AW-1:0]   wr_off,
  input  logic [7:0]      wr_len
);

  logic [ENTRIES-1:0] valid_q;
  logic [ID_W-1:0]    id_q  [ENTRIES];
  logic [AW-1:0]      off_q [ENTRIES];
  logic [7:0]         len_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] tail_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (id_q[g] == lk_id);
    assign tail_vec[g]  = valid_q[g] && (off_q[g] == tail_off);
  end

  always_comb begin
    lk_hit   = 1'b0;
    lk_off   = '0;
    lk_len   = '0;
    tail_hit = 1'b0;
    tail_len = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        lk_hit = 1'b1;
        lk_off = off_q[i];
        lk_len = len_q[i];
      end
      if (tail_vec[i]) begin
        tail_hit = 1'b1;
        tail_len = len_q[i];
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IXW'(i);
    end
  end

  assign full = &valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        id_q[i]  <= '0;
        off_q[i] <= '0;
        len_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && (wr_idx == IXW'(i))) begin
          valid_q[i] <= 1'b1;
          id_q[i]    <= wr_id;
          off_q[i]   <= wr_off;
          len_q[i]   <= wr_len;
        end else if (inv_en && tail_vec[i]) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match_vec)); // R3
  AST_TAIL_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tail_vec)); // R6
  AST_WR_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !valid_q[wr_idx]); // R7

endmodule

// File: rtl/rec_ring_cache.sv
module rec_ring_cache
  import rrc_pkg::*;
#(
  parameter int ID_W        = 8,
  parameter int RING_BYTES  = 64,
  parameter int DIR_ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      cfg_max_len,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  output logic            req_ready,
  output logic            out_valid,
  output logic [7:0]      out_byte,
  output logic            out_last,
  output logic            mem_req_valid,
  output logic [ID_W-1:0] mem_req_id,
  input  logic            mem_req_ready,
  input  logic            mem_hdr_valid,
  input  logic [7:0]      mem_hdr_len,
  input  logic            mem_dat_valid,
  input  logic [7:0]      mem_dat_byte,
  output logic            mem_dat_ready
);

  localparam int AW  = (RING_BYTES > 1) ? $clog2(RING_BYTES) : 1;
  localparam int UW  = AW + 1;
  localparam int IXW = (DIR_ENTRIES > 1) ? $clog2(DIR_ENTRIES) : 1;
  localparam logic [15:0] RING16 = 16'(RING_BYTES);

  rrc_state_e      state_q;
  logic [ID_W-1:0] id_q;
  logic [7:0]      len_q;
  logic [7:0]      cnt_q;
  logic [AW-1:0]   rd_ptr_q;
  logic [AW-1:0]   head_q;
  logic [AW-1:0]   tail_q;
  logic [UW-1:0]   used_q;
  logic            store_q;
  logic [IXW-1:0]  slot_q;
  logic [AW-1:0]   off_q;

  // directory and ring connections
  logic            lk_hit;
  logic [AW-1:0]   lk_off;
  logic [7:0]      lk_len;
  logic            tail_hit;
  logic [7:0]      tail_len;
  logic            dir_full;
  logic [IXW-1:0]  free_idx;
  logic [7:0]      ring_rdata;

  // named internal events
  logic [15:0] free_bytes;
  logic        need_evict;
  logic        evict_fire;
  logic        fill_beat;
  logic        fill_last;
  logic        dir_wr;
  logic        ring_we;
  logic        hit_last;

  assign free_bytes = rrc_free(16'(used_q), RING16);
  assign need_evict = (free_bytes < 16'(len_q)) || dir_full;
  assign evict_fire = (state_q == ST_EVICT) && need_evict;
  assign fill_beat  = (state_q == ST_FILL) && mem_dat_valid;
  assign fill_last  = fill_beat && (cnt_q == len_q - 8'd1);
  assign dir_wr     = fill_last && store_q;
  assign ring_we    = fill_beat && store_q;
  assign hit_last   = (state_q == ST_HIT) && (cnt_q == len_q - 8'd1);

  rrc_dir #(
    .ENTRIES(DIR_ENTRIES),
    .ID_W   (ID_W),
    .AW     (AW),
    .IXW    (IXW)
  ) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_id   (req_id),
    .lk_hit  (lk_hit),
    .lk_off  (lk_off),
    .lk_len  (lk_len),
    .tail_off(tail_q),
    .tail_hit(tail_hit),
    .tail_len(tail_len),
    .inv_en  (evict_fire),
    .full    (dir_full),
    .free_idx(free_idx),
    .wr_en   (dir_wr),
    .wr_idx  (slot_q),
    .wr_id   (id_q),
    .wr_off  (off_q),
    .wr_len  (len_q)
  );

  rrc_ring #(
    .DEPTH(RING_BYTES),
    .AW   (AW)
  ) u_ring (
    .clk  (clk),
    .we   (ring_we),
    .waddr(head_q),
    .wdata(mem_dat_byte),
    .raddr(rd_ptr_q),
    .rdata(ring_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      id_q     <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      used_q   <= '0;
      store_q  <= 1'b0;
      slot_q   <= '0;
      off_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            id_q  <= req_id;
            cnt_q <= '0;
            if (lk_hit) begin
              rd_ptr_q <= lk_off;
              len_q    <= lk_len;
              state_q  <= ST_HIT;
            end else begin
              state_q <= ST_MREQ;
            end
          end
        end
        ST_HIT: begin
          cnt_q    <= cnt_q + 8'd1;
          rd_ptr_q <= AW'(rrc_wrap_add(16'(rd_ptr_q), 16'd1, RING16));
          if (hit_last) state_q <= ST_IDLE;
        end
        ST_MREQ: begin
          if (mem_req_ready) state_q <= ST_HDR;
        end
        ST_HDR: begin
          if (mem_hdr_valid) begin
            len_q   <= mem_hdr_len;
            cnt_q   <= '0;
            store_q <= 1'b0;
            if (mem_hdr_len == 8'd0) begin
              state_q <= ST_IDLE;
            end else if (rrc_storable(mem_hdr_len, cfg_max_len, RING16)) begin
              state_q <= ST_EVICT;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_EVICT: begin
          if (need_evict) begin
            tail_q <= AW'(rrc_wrap_add(16'(tail_q), 16'(tail_len), RING16));
            used_q <= used_q - UW'(tail_len);
          end else begin
            store_q <= 1'b1;
            slot_q  <= free_idx;
            off_q   <= head_q;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_dat_valid) begin
            cnt_q <= cnt_q + 8'd1;
            if (store_q) head_q <= AW'(rrc_wrap_add(16'(head_q), 16'd1, RING16));
            if (fill_last) begin
              if (store_q) used_q <= used_q + UW'(len_q);
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_id    = id_q;
  assign mem_dat_ready = (state_q == ST_FILL);
  assign out_valid     = (state_q == ST_HIT) || fill_beat;
  assign out_byte      = (state_q == ST_HIT) ? ring_rdata : mem_dat_byte;
  assign out_last      = hit_last || fill_last;

  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n) 16'(used_q) <= RING16); // R6
  AST_EVICT_HAS_TAIL: assert property (@(posedge clk) disable iff (!rst_n) evict_fire |-> tail_hit); // R6
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) ring_we |-> (16'(used_q) + 16'(cnt_q) < RING16)); // R8
  AST_STORE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) dir_wr |-> (len_q <= cfg_max_len && 16'(len_q) <= RING16)); // R4
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_id))); // R2
  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (req_ready && req_valid && lk_hit) |=> (out_valid && !mem_req_valid)); // R3

endmodule

// File: tb/rec_ring_cache_test.sv
module rec_ring_cache_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_max_len = 8'd255;
  logic       req_valid = 1'b0;
  logic [7:0] req_id = '0;
  logic       req_ready;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_last;
  logic       mem_req_valid;
  logic [7:0] mem_req_id;
  logic       mem_req_ready = 1'b0;
  logic       mem_hdr_valid = 1'b0;
  logic [7:0] mem_hdr_len = '0;
  logic       mem_dat_valid = 1'b0;
  logic [7:0] mem_dat_byte = '0;
  logic       mem_dat_ready;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rec_ring_cache #(.ID_W(8), .RING_BYTES(64), .DIR_ENTRIES(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len),
    .req_valid(req_valid), .req_id(req_id), .req_ready(req_ready),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
    .mem_req_valid(mem_req_valid), .mem_req_id(mem_req_id), .mem_req_ready(mem_req_ready),
    .mem_hdr_valid(mem_hdr_valid), .mem_hdr_len(mem_hdr_len),
    .mem_dat_valid(mem_dat_valid), .mem_dat_byte(mem_dat_byte), .mem_dat_ready(mem_dat_ready)
  );

  function automatic logic [7:0] rec_byte(input int id, input int i);
    return 8'((id * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One lookup with a memory model; checks hit/miss, content, length and hit timing.
  task automatic lookup(input int id, input int len, input bit exp_hit, input string tag);
    int  phase = 0;
    int  sent = 0;
    int  got = 0;
    int  cyc = 0;
    int  mism = 0;
    int  id_bad = 0;
    int  last_cyc = 0;
    bit  saw_req = 1'b0;
    bit  done = 1'b0;
    @(negedge clk);
    check(req_ready === 1'b1, tag, "idle before lookup", int'(req_ready), 1);
    req_valid = 1'b1;
    req_id    = 8'(id);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 800) begin
      cyc++;
      mem_req_ready = 1'b0;
      mem_hdr_valid = 1'b0;
      mem_dat_valid = 1'b0;
      if (phase == 0 && mem_req_valid) begin
        saw_req = 1'b1;
        if (mem_req_id !== 8'(id)) id_bad++;
        if (cyc >= 2) begin
          mem_req_ready = 1'b1;
          phase = 1;
        end
      end else if (phase == 1) begin
        mem_hdr_valid = 1'b1;
        mem_hdr_len   = 8'(len);
        phase = 2;
      end else if (phase == 2 && mem_dat_ready && (cyc % 3) != 0) begin
        mem_dat_valid = 1'b1;
        mem_dat_byte  = rec_byte(id, sent);
        sent++;
      end
      #1;
      if (out_valid === 1'b1) begin
        if (out_byte !== rec_byte(id, got)) mism++;
        got++;
        if (out_last === 1'b1) begin
          done = 1'b1;
          last_cyc = cyc;
        end
      end
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_hdr_valid = 1'b0;
    mem_dat_valid = 1'b0;
    check(saw_req == !exp_hit, tag, $sformatf("id %0d memory fetch issued", id),
          int'(saw_req), int'(!exp_hit));
    check(got == len, tag, $sformatf("id %0d bytes delivered", id), got, len);
    check(mism == 0, tag, $sformatf("id %0d byte mismatches", id), mism, 0);
    if (exp_hit)
      check(last_cyc == len, tag, $sformatf("id %0d hit stream cycles", id), last_cyc, len);
    else
      check(id_bad == 0, tag, $sformatf("id %0d fetch id errors", id), id_bad, 0);
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(mem_req_valid === 1'b0, "R1", "mem_req_valid after reset", int'(mem_req_valid), 0);
    check(mem_dat_ready === 1'b0, "R1", "mem_dat_ready after reset", int'(mem_dat_ready), 0);
  endtask

  task automatic t_basic;
    cfg_max_len = 8'd255;
    lookup(1, 10, 1'b0, "R1");   // cold miss, R2 forwarding
    lookup(1, 10, 1'b1, "R3");
  endtask

  task automatic t_limit;
    cfg_max_len = 8'd12;
    lookup(2, 13, 1'b0, "R4");
    lookup(2, 13, 1'b0, "R4");   // one over limit: not stored
    lookup(3, 12, 1'b0, "R2");
    lookup(3, 12, 1'b1, "R4");   // exactly at limit: stored
    cfg_max_len = 8'd0;
    lookup(9, 1, 1'b0, "R4");
    lookup(9, 1, 1'b0, "R4");    // limit 0 stores nothing
  endtask

  task automatic t_ring_size;
    cfg_max_len = 8'd255;
    lookup(4, 65, 1'b0, "R5");
    lookup(4, 65, 1'b0, "R5");   // longer than ring: forwarded only
  endtask

  task automatic t_evict_bytes;
    lookup(1, 10, 1'b1, "R9");   // hit on oldest record
    lookup(5, 30, 1'b0, "R6");
    lookup(6, 20, 1'b0, "R6");   // reclaims id1 (oldest), wraps the ring end
    lookup(1, 10, 1'b0, "R9");   // recent hit did not protect it
    lookup(5, 30, 1'b1, "R6");
    lookup(6, 20, 1'b1, "R8");   // record crossing the ring end
    lookup(1, 10, 1'b1, "R6");
  endtask

  task automatic t_dir_full;
    lookup(7, 2, 1'b0, "R7");    // fourth entry, directory now full
    lookup(8, 1, 1'b0, "R7");    // bytes free but no entry: reclaims id5
    lookup(6, 20, 1'b1, "R7");
    lookup(1, 10, 1'b1, "R7");
    lookup(7, 2, 1'b1, "R7");
    lookup(8, 1, 1'b1, "R7");
    lookup(5, 30, 1'b0, "R7");   // reclaimed by entry pressure
    lookup(6, 20, 1'b0, "R6");   // next oldest went for id5
    lookup(3, 12, 1'b0, "R6");   // reclaimed earlier
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_limit();
    t_ring_size();
    t_evict_bytes();
    t_dir_full();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule